// File: doc/BRIEF.md
# Paged Data Window Address Expander

This block widens a 16-bit CPU address to a 22-bit external address through one fixed 4-Kbyte data window. An 8-bit page register, reached over a small register bus, names one of 256 pages. When the window is switched on and the CPU address lies in the window, the top nibble of the CPU address is dropped. The page number takes its place on external address bits 19..12. The two highest external lines can each be forced high by their own enable bit.

Every access that falls in the window also asserts a data-window chip-select, which the external data memory uses. Accesses outside the window, or any access while the window is off, pass the CPU address through unchanged and leave the upper external lines low. Two port direction registers, 7 and 6 bits wide, share the register bus.

The address and chip-select outputs are combinational from the CPU address, the control inputs and the stored registers. A register write lands on the clock edge that follows it.

Top module: `pdw_expander`

## Requirements
- R1: After reset, the page register and both direction registers read as $00.
- R2: A write to offset $34 stores all 8 bits in the page register. The value reads back at once, and every window access from the next cycle onward uses it.
- R3: When `win_en` is 1 and `cpu_addr[15:12]` is 4'h7, `ext_addr[19:12]` equals the page register. Page bit 7 maps to address bit 19 and page bit 0 to address bit 12.
- R4: The window covers $7000 to $7FFF inclusive. $7000 and $7FFF are remapped; $6FFF and $8000 are not.
- R5: With `win_en` at 0, or with the address outside the window, `ext_addr` equals `cpu_addr` zero-extended to 22 bits and `win_cs` is 0.
- R6: During a window access, `ext_addr[20]` equals `ext_force_en[0]` and `ext_addr[21]` equals `ext_force_en[1]`. Outside a window access both bits are 0.
- R7: `win_cs` is 1 exactly when `cpu_access` is 1 and the access is a window access.
- R8: The direction register at offset $32 holds 7 bits and the one at $33 holds 6 bits. Their unimplemented upper bits read as 0.
- R9: Reads of any offset other than $32, $33 and $34 return $00. Writes to such offsets change no register.
- R10: `ext_addr[11:0]` always equals `cpu_addr[11:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr`, combinational |
| cpu_addr | input | 16 | CPU address |
| cpu_access | input | 1 | CPU access strobe |
| win_en | input | 1 | Data window enable |
| ext_force_en | input | 2 | Bit 0 forces address line 20 high and bit 1 forces line 21 high during window accesses |
| ext_addr | output | 22 | Expanded external address |
| win_cs | output | 1 | Data window chip-select |

## Verification
On every cycle, the assertions check the pass-through of the low twelve bits and the untouched address outside the window. They also check that the forced upper lines follow their enables during window accesses, that the chip-select agrees with the strobe and the window decode, and that a page write steers the very next window access. The bench scenarios are needed for the rest. They show the exact remapped values of chosen pages, the edges of the window at $6FFF, $7000, $7FFF and $8000, and the masking of the direction registers. They also show that writes to unmapped offsets leave every register as it was.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
  localparam int unsigned REG_AW = 8;
  localparam int unsigned REG_DW = 8;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_PAGE,
    SEL_DIRA,
    SEL_DIRB
  } reg_sel_e;
endpackage

// File: rtl/pdw_rst_sync.sv
module pdw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/pdw_regfile.sv
module pdw_regfile
  import pdw_pkg::*;
#(
  parameter int unsigned          PAGE_W   = 8,
  parameter int unsigned          DIRA_W   = 7,
  parameter int unsigned          DIRB_W   = 6,
  parameter logic [REG_AW-1:0]    PAGE_OFS = 8'h34,
  parameter logic [REG_AW-1:0]    DIRA_OFS = 8'h32,
  parameter logic [REG_AW-1:0]    DIRB_OFS = 8'h33
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  output logic [REG_DW-1:0] rdata,
  output logic [PAGE_W-1:0] page
);
  reg_sel_e          sel;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [DIRA_W-1:0] dira_q, dira_d;
  logic [DIRB_W-1:0] dirb_q, dirb_d;
  logic              page_ce, dira_ce, dirb_ce;

  // offset decode
  always_comb begin
    if (addr == PAGE_OFS)      sel = SEL_PAGE;
    else if (addr == DIRA_OFS) sel = SEL_DIRA;
    else if (addr == DIRB_OFS) sel = SEL_DIRB;
    else                       sel = SEL_NONE;
  end

  // next state and clock enables
  always_comb begin
    page_d  = wdata[PAGE_W-1:0];
    dira_d  = wdata[DIRA_W-1:0];
    dirb_d  = wdata[DIRB_W-1:0];
    page_ce = wr_en && (sel == SEL_PAGE);
    dira_ce = wr_en && (sel == SEL_DIRA);
    dirb_ce = wr_en && (sel == SEL_DIRB);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
    end else if (page_ce) begin
      page_q <= page_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dira_q <= '0;
    end else if (dira_ce) begin
      dira_q <= dira_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirb_q <= '0;
    end else if (dirb_ce) begin
      dirb_q <= dirb_d;
    end
  end

  // read mux, unimplemented bits and offsets return zero
  always_comb begin
    rdata = '0;
    unique case (sel)
      SEL_PAGE: rdata[PAGE_W-1:0] = page_q;
      SEL_DIRA: rdata[DIRA_W-1:0] = dira_q;
      SEL_DIRB: rdata[DIRB_W-1:0] = dirb_q;
      default:  rdata = '0;
    endcase
  end

  assign page = page_q;
endmodule

// File: rtl/pdw_addr_map.sv
module pdw_addr_map #(
  parameter int unsigned                    CPU_AW      = 16,
  parameter int unsigned                    WIN_SHIFT   = 12,
  parameter int unsigned                    PAGE_W      = 8,
  parameter int unsigned                    EXT_FORCE_N = 2,
  parameter logic [CPU_AW-WIN_SHIFT-1:0]    WIN_TAG     = 4'h7
) (
  input  logic [CPU_AW-1:0]                       cpu_addr,
  input  logic                                    cpu_access,
  input  logic                                    win_en,
  input  logic [PAGE_W-1:0]                       page,
  input  logic [EXT_FORCE_N-1:0]                  force_en,
  output logic [WIN_SHIFT+PAGE_W+EXT_FORCE_N-1:0] ext_addr,
  output logic                                    win_cs
);
  localparam int unsigned TAG_W  = CPU_AW - WIN_SHIFT;
  localparam int unsigned BASE_W = WIN_SHIFT + PAGE_W;

  logic                   hit;
  logic [BASE_W-1:0]      base;
  logic [EXT_FORCE_N-1:0] upper;

  assign hit = win_en && (cpu_addr[CPU_AW-1:WIN_SHIFT] == WIN_TAG);

  always_comb begin
    base = '0;
    base[WIN_SHIFT-1:0] = cpu_addr[WIN_SHIFT-1:0];
    if (hit) begin
      base[WIN_SHIFT +: PAGE_W] = page;
    end else begin
      base[WIN_SHIFT +: TAG_W] = cpu_addr[CPU_AW-1:WIN_SHIFT];
    end
  end

  // one forced line per enable bit
  for (genvar g = 0; g < EXT_FORCE_N; g++) begin : g_force
    assign upper[g] = hit && force_en[g];
  end

  assign ext_addr = {upper, base};
  assign win_cs   = hit && cpu_access;
endmodule

// File: rtl/pdw_expander.sv
module pdw_expander
  import pdw_pkg::*;
#(
  parameter int unsigned                 CPU_AW      = 16,
  parameter int unsigned                 WIN_SHIFT   = 12,
  parameter int unsigned                 PAGE_W      = 8,
  parameter int unsigned                 EXT_FORCE_N = 2,
  parameter logic [CPU_AW-WIN_SHIFT-1:0] WIN_TAG     = 4'h7,
  parameter int unsigned                 DIRA_W      = 7,
  parameter int unsigned                 DIRB_W      = 6,
  parameter logic [REG_AW-1:0]           PAGE_OFS    = 8'h34,
  parameter logic [REG_AW-1:0]           DIRA_OFS    = 8'h32,
  parameter logic [REG_AW-1:0]           DIRB_OFS    = 8'h33,
  parameter int unsigned                 SYNC_STAGES = 2
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    reg_wr,
  input  logic [REG_AW-1:0]                       reg_addr,
  input  logic [REG_DW-1:0]                       reg_wdata,
  output logic [REG_DW-1:0]                       reg_rdata,
  input  logic [CPU_AW-1:0]                       cpu_addr,
  input  logic                                    cpu_access,
  input  logic                                    win_en,
  input  logic [EXT_FORCE_N-1:0]                  ext_force_en,
  output logic [WIN_SHIFT+PAGE_W+EXT_FORCE_N-1:0] ext_addr,
  output logic                                    win_cs
);
  logic              rst_sync_n;
  logic [PAGE_W-1:0] page;

  pdw_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  pdw_regfile #(
    .PAGE_W   (PAGE_W),
    .DIRA_W   (DIRA_W),
    .DIRB_W   (DIRB_W),
    .PAGE_OFS (PAGE_OFS),
    .DIRA_OFS (DIRA_OFS),
    .DIRB_OFS (DIRB_OFS)
  ) u_regfile (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .page  (page)
  );

  pdw_addr_map #(
    .CPU_AW      (CPU_AW),
    .WIN_SHIFT   (WIN_SHIFT),
    .PAGE_W      (PAGE_W),
    .EXT_FORCE_N (EXT_FORCE_N),
    .WIN_TAG     (WIN_TAG)
  ) u_addr_map (
    .cpu_addr   (cpu_addr),
    .cpu_access (cpu_access),
    .win_en     (win_en),
    .page       (page),
    .force_en   (ext_force_en),
    .ext_addr   (ext_addr),
    .win_cs     (win_cs)
  );
endmodule

// File: rtl/pdw_expander_chk.sv
module pdw_expander_chk #(
  parameter int unsigned                 CPU_AW      = 16,
  parameter int unsigned                 WIN_SHIFT   = 12,
  parameter int unsigned                 PAGE_W      = 8,
  parameter int unsigned                 EXT_FORCE_N = 2,
  parameter logic [CPU_AW-WIN_SHIFT-1:0] WIN_TAG     = 4'h7,
  parameter int unsigned                 DIRA_W      = 7,
  parameter int unsigned                 REG_AW      = 8,
  parameter int unsigned                 REG_DW      = 8,
  parameter logic [REG_AW-1:0]           PAGE_OFS    = 8'h34,
  parameter logic [REG_AW-1:0]           DIRA_OFS    = 8'h32
) (
  input logic                                    clk,
  input logic                                    srst_n,
  input logic                                    reg_wr,
  input logic [REG_AW-1:0]                       reg_addr,
  input logic [REG_DW-1:0]                       reg_wdata,
  input logic [REG_DW-1:0]                       reg_rdata,
  input logic [CPU_AW-1:0]                       cpu_addr,
  input logic                                    cpu_access,
  input logic                                    win_en,
  input logic [EXT_FORCE_N-1:0]                  ext_force_en,
  input logic [WIN_SHIFT+PAGE_W+EXT_FORCE_N-1:0] ext_addr,
  input logic                                    win_cs
);
  localparam int unsigned EXT_AW = WIN_SHIFT + PAGE_W + EXT_FORCE_N;

  logic in_win;
  assign in_win = win_en && (cpu_addr[CPU_AW-1:WIN_SHIFT] == WIN_TAG);

  a_r5_miss_passthru: assert property (@(posedge clk) disable iff (!srst_n)
    !in_win |-> (ext_addr == {{(EXT_AW-CPU_AW){1'b0}}, cpu_addr}) && !win_cs);

  a_r6_force_follows: assert property (@(posedge clk) disable iff (!srst_n)
    in_win |-> ext_addr[EXT_AW-1 -: EXT_FORCE_N] == ext_force_en);

  a_r7_cs_only_on_hit: assert property (@(posedge clk) disable iff (!srst_n)
    win_cs |-> cpu_access && in_win);

  a_r7_cs_on_every_hit: assert property (@(posedge clk) disable iff (!srst_n)
    (cpu_access && in_win) |-> win_cs);

  a_r10_low_bits: assert property (@(posedge clk) disable iff (!srst_n)
    ext_addr[WIN_SHIFT-1:0] == cpu_addr[WIN_SHIFT-1:0]);

  a_r2_page_next_access: assert property (@(posedge clk) disable iff (!srst_n)
    (reg_wr && reg_addr == PAGE_OFS) |=>
      (!in_win || ext_addr[WIN_SHIFT +: PAGE_W] == $past(reg_wdata[PAGE_W-1:0])));

  a_r8_dira_top_zero: assert property (@(posedge clk) disable iff (!srst_n)
    (reg_addr == DIRA_OFS) |-> reg_rdata[REG_DW-1:DIRA_W] == '0);
endmodule

bind pdw_expander pdw_expander_chk #(
  .CPU_AW      (CPU_AW),
  .WIN_SHIFT   (WIN_SHIFT),
  .PAGE_W      (PAGE_W),
  .EXT_FORCE_N (EXT_FORCE_N),
  .WIN_TAG     (WIN_TAG),
  .DIRA_W      (DIRA_W),
  .REG_AW      (pdw_pkg::REG_AW),
  .REG_DW      (pdw_pkg::REG_DW),
  .PAGE_OFS    (PAGE_OFS),
  .DIRA_OFS    (DIRA_OFS)
) u_chk (
  .clk          (clk),
  .srst_n       (rst_sync_n),
  .reg_wr       (reg_wr),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .reg_rdata    (reg_rdata),
  .cpu_addr     (cpu_addr),
  .cpu_access   (cpu_access),
  .win_en       (win_en),
  .ext_force_en (ext_force_en),
  .ext_addr     (ext_addr),
  .win_cs       (win_cs)
);

// File: tb/test_pdw_expander.sv
module test_pdw_expander;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic [15:0] cpu_addr;
  logic        cpu_access;
  logic        win_en;
  logic [1:0]  ext_force_en;
  logic [21:0] ext_addr;
  logic        win_cs;

  int checks = 0;
  int errors = 0;

  pdw_expander i_pdw_expander (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .cpu_addr     (cpu_addr),
    .cpu_access   (cpu_access),
    .win_en       (win_en),
    .ext_force_en (ext_force_en),
    .ext_addr     (ext_addr),
    .win_cs       (win_cs)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // spec model of the expanded address
  function automatic logic [21:0] model(input logic [15:0] a, input logic en,
                                        input logic [7:0] pg, input logic [1:0] f);
    if (en && a >= 16'h7000 && a <= 16'h7FFF)
      return {f, pg, a[11:0]};
    return {6'd0, a};
  endfunction

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic cpu_probe(input string req, input logic [15:0] a, input logic acc,
                           input logic en, input logic [1:0] f, input logic [7:0] pg);
    @(negedge clk);
    cpu_addr = a; cpu_access = acc; win_en = en; ext_force_en = f;
    #1;
    check(req, "ext_addr", 32'(ext_addr), 32'(model(a, en, pg, f)));
    check(req, "win_cs", 32'(win_cs),
          32'(acc && en && a >= 16'h7000 && a <= 16'h7FFF));
  endtask

  task automatic t_reset;
    logic [7:0] d;
    reg_read(8'h34, d); check("R1", "page after reset", 32'(d), 32'h00);
    reg_read(8'h32, d); check("R1", "dir A after reset", 32'(d), 32'h00);
    reg_read(8'h33, d); check("R1", "dir B after reset", 32'(d), 32'h00);
    cpu_probe("R1", 16'h7123, 1'b1, 1'b1, 2'b00, 8'h00);
  endtask

  task automatic t_page_rw;
    logic [7:0] d;
    reg_write(8'h34, 8'hA5);
    reg_read(8'h34, d); check("R2", "page readback", 32'(d), 32'hA5);
    reg_write(8'h34, 8'h5A);
    cpu_probe("R2", 16'h7ABC, 1'b1, 1'b1, 2'b00, 8'h5A);
  endtask

  task automatic t_window_map;
    reg_write(8'h34, 8'h81);
    cpu_probe("R3", 16'h7ABC, 1'b1, 1'b1, 2'b00, 8'h81);
    reg_write(8'h34, 8'hFF);
    cpu_probe("R3", 16'h7456, 1'b1, 1'b1, 2'b00, 8'hFF);
    cpu_probe("R10", 16'h7FED, 1'b0, 1'b1, 2'b11, 8'hFF);
  endtask

  task automatic t_boundaries;
    reg_write(8'h34, 8'h3C);
    cpu_probe("R4", 16'h7000, 1'b1, 1'b1, 2'b00, 8'h3C);
    cpu_probe("R4", 16'h7FFF, 1'b1, 1'b1, 2'b00, 8'h3C);
    cpu_probe("R4", 16'h6FFF, 1'b1, 1'b1, 2'b11, 8'h3C);
    cpu_probe("R4", 16'h8000, 1'b1, 1'b1, 2'b11, 8'h3C);
  endtask

  task automatic t_disabled;
    cpu_probe("R5", 16'h7800, 1'b1, 1'b0, 2'b11, 8'h3C);
    cpu_probe("R5", 16'hFFFF, 1'b1, 1'b0, 2'b11, 8'h3C);
    cpu_probe("R10", 16'h1234, 1'b1, 1'b0, 2'b00, 8'h3C);
  endtask

  task automatic t_force;
    cpu_probe("R6", 16'h7010, 1'b1, 1'b1, 2'b01, 8'h3C);
    cpu_probe("R6", 16'h7010, 1'b1, 1'b1, 2'b10, 8'h3C);
    cpu_probe("R6", 16'h7010, 1'b1, 1'b1, 2'b11, 8'h3C);
    cpu_probe("R6", 16'h2010, 1'b1, 1'b1, 2'b11, 8'h3C);
  endtask

  task automatic t_strobe;
    cpu_probe("R7", 16'h7222, 1'b0, 1'b1, 2'b00, 8'h3C);
    cpu_probe("R7", 16'h7222, 1'b1, 1'b1, 2'b00, 8'h3C);
    cpu_probe("R7", 16'h3222, 1'b1, 1'b1, 2'b00, 8'h3C);
  endtask

  task automatic t_dir_regs;
    logic [7:0] d;
    reg_write(8'h32, 8'hFF);
    reg_read(8'h32, d); check("R8", "dir A masked", 32'(d), 32'h7F);
    reg_write(8'h33, 8'hFF);
    reg_read(8'h33, d); check("R8", "dir B masked", 32'(d), 32'h3F);
    reg_write(8'h33, 8'h15);
    reg_read(8'h33, d); check("R8", "dir B value", 32'(d), 32'h15);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    reg_write(8'h35, 8'hEE);
    reg_write(8'h00, 8'hEE);
    reg_write(8'hB4, 8'hEE);
    reg_read(8'h35, d); check("R9", "unmapped read", 32'(d), 32'h00);
    reg_read(8'h31, d); check("R9", "unmapped read", 32'(d), 32'h00);
    reg_read(8'h34, d); check("R9", "page untouched", 32'(d), 32'h3C);
    reg_read(8'h32, d); check("R9", "dir A untouched", 32'(d), 32'h7F);
    reg_read(8'h33, d); check("R9", "dir B untouched", 32'(d), 32'h15);
    cpu_probe("R9", 16'h7777, 1'b1, 1'b1, 2'b00, 8'h3C);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    cpu_addr = '0; cpu_access = 1'b0; win_en = 1'b0; ext_force_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_page_rw();
    t_window_map();
    t_boundaries();
    t_disabled();
    t_force();
    t_strobe();
    t_dir_regs();
    t_unmapped();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule